// File: doc/BRIEF.md
# Translation Entry Address Match with Low-End Exclusion Hole

This block decides whether a 64-bit effective address hits one translation entry. It takes the address, the entry's 52-bit page number, a valid flag, a page-size code and an exclusion flag. It produces one hit signal. Address bits are numbered from 0 (most significant) to 63 (least significant), so a 4 KB granule index ends at bit 51. The page size decides how many of the low page-number bits (bits 34 to 51) take no part in the compare. Bits 0 to 33 must always be equal.

When the exclusion flag is set on a page larger than 4 KB, the page-number bits that the size leaves unused are read as a hole descriptor instead of being compared. Their run of low-order ones, n, gives a hole of 2^n granules at the bottom of the page. Addresses whose granule index inside the page falls within the hole miss, so smaller entries can claim that region. The block has no state: the hit follows the inputs combinationally.

Top module: `tlbx_match`

## Requirements
- R1: When `valid_i` is 0, `match_o` is 0 for every other input combination.
- R2: Size codes are 0=4 KB, 1=64 KB, 2=1 MB, 3=16 MB, 4=256 MB, 5=1 GB. Codes 6 and 7 never match.
- R3: A hit requires address bits 0–33 to equal page-number bits 0–33, for every size.
- R4: With size code 0, a hit requires address bits 34–51 to equal page-number bits 34–51.
- R5: Compare groups are bits 48–51, 44–47, 40–43, 36–39 and 34–35. Each group is ignored once the size code reaches 1, 2, 3, 4 and 5 respectively, and is otherwise compared in full. This holds whether the exclusion flag is set or clear.
- R6: With size code 0 the exclusion flag has no effect on `match_o`.
- R7: With the exclusion flag set and size code 1–5, let u be the number of ignored bits (4, 8, 12, 16 or 18) and n the count of contiguous ones from bit 51 upward in the page number's ignored bits. An address whose in-page granule index (its ignored bits read as an unsigned number, bit 51 least significant) is below 2^n does not match. Indexes at or above 2^n match as normal.
- R8: A descriptor that is not of the form 2^n−1 is sized by its low run of ones alone. A run that covers all u bits is limited to n = u−1, so the hole never covers the whole page.
- R9: Address bits 52–63 have no effect on `match_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ea_i | input | 64 | Effective address, bit 0 most significant |
| epn_i | input | 52 | Entry page number, bit 0 most significant |
| valid_i | input | 1 | Entry holds a live translation |
| size_i | input | 3 | Page-size code |
| excl_i | input | 1 | Exclusion-hole enable |
| match_o | output | 1 | Address hits the entry |

## Verification
The hardest situation to reach is the hole boundary. The descriptor and the address offset must both be set so that the granule index sits exactly at 2^n−1 or at 2^n, while the page's upper bits still match. The bench builds every descriptor from 2^n−1 for n from 0 up to the full ignored width, plus a broken pattern. It then puts the address at the offsets that straddle each boundary. It also flips every address bit on its own at the top offset, so that the compare of each group is seen at each size.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int EA_W  = 64;
  localparam int EPN_W = 52;
  localparam int LO_W  = 18;
  localparam int HI_W  = EPN_W - LO_W;
  localparam int NGRP  = 5;
  localparam int SZ_W  = 3;
  localparam int NSIZE = NGRP + 1;

  typedef enum logic [SZ_W-1:0] {
    SZ_4K   = 3'd0,
    SZ_64K  = 3'd1,
    SZ_1M   = 3'd2,
    SZ_16M  = 3'd3,
    SZ_256M = 3'd4,
    SZ_1G   = 3'd5
  } pg_size_e;

  // group g occupies low-field bits [grp_lsb(g) +: grp_w(g)], low-field bit 0 = address bit 51
  function automatic int grp_w(int g);
    return (g == NGRP - 1) ? 2 : 4;
  endfunction

  function automatic int grp_lsb(int g);
    int s;
    s = 0;
    for (int i = 0; i < g; i++) s += grp_w(i);
    return s;
  endfunction
endpackage

// File: rtl/tlbx_size_decode.sv
module tlbx_size_decode
  import tlbx_pkg::*;
(
  input  logic [SZ_W-1:0] size_i,
  output logic [NGRP-1:0] force_o,
  output logic [LO_W-1:0] unused_o,
  output logic [LO_W-1:0] top_o,
  output logic            size_ok_o
);
  assign size_ok_o = (size_i < SZ_W'(NSIZE));

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LSB = grp_lsb(g);
    localparam int W   = grp_w(g);
    assign force_o[g] = size_ok_o && (size_i > SZ_W'(g));
    assign unused_o[LSB +: W] = {W{force_o[g]}};
  end

  // highest unused bit: the hole may never claim it
  always_comb begin
    top_o = '0;
    for (int i = 0; i < LO_W; i++) begin
      if (unused_o[i] && ((i == LO_W - 1) || !unused_o[(i + 1) % LO_W])) top_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/tlbx_hole_decode.sv
module tlbx_hole_decode
  import tlbx_pkg::*;
(
  input  logic            excl_i,
  input  logic [LO_W-1:0] unused_i,
  input  logic [LO_W-1:0] top_i,
  input  logic [LO_W-1:0] epn_lo_i,
  input  logic [LO_W-1:0] ea_lo_i,
  output logic            in_hole_o
);
  logic [LO_W-1:0] run;
  logic [LO_W-1:0] must_zero;

  // run[i] set while descriptor bits 0..i are all ones
  assign run[0] = epn_lo_i[0];
  for (genvar i = 1; i < LO_W; i++) begin : g_run
    assign run[i] = run[i-1] & epn_lo_i[i];
  end

  assign must_zero = unused_i & (~run | top_i);
  assign in_hole_o = excl_i && (|unused_i) && !(|(must_zero & ea_lo_i));
endmodule

// File: rtl/tlbx_group_cmp.sv
module tlbx_group_cmp #(
  parameter int W = 4
) (
  input  logic [W-1:0] ea_i,
  input  logic [W-1:0] epn_i,
  input  logic         force_i,
  output logic         ok_o
);
  assign ok_o = force_i || (ea_i == epn_i);
endmodule

// File: rtl/tlbx_match.sv
module tlbx_match
  import tlbx_pkg::*;
(
  input  logic [0:EA_W-1]  ea_i,
  input  logic [0:EPN_W-1] epn_i,
  input  logic             valid_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic             excl_i,
  output logic             match_o
);
  logic [LO_W-1:0] ea_lo, epn_lo;
  logic [NGRP-1:0] force_grp, grp_ok;
  logic [LO_W-1:0] unused, top;
  logic            size_ok, in_hole, hi_eq;

  for (genvar j = 0; j < LO_W; j++) begin : g_lo
    assign ea_lo[j]  = ea_i[EPN_W-1-j];
    assign epn_lo[j] = epn_i[EPN_W-1-j];
  end

  assign hi_eq = (ea_i[0:HI_W-1] == epn_i[0:HI_W-1]);

  tlbx_size_decode u_size (
    .size_i   (size_i),
    .force_o  (force_grp),
    .unused_o (unused),
    .top_o    (top),
    .size_ok_o(size_ok)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_cmp
    localparam int LSB = grp_lsb(g);
    localparam int W   = grp_w(g);
    tlbx_group_cmp #(.W(W)) u_grp (
      .ea_i   (ea_lo[LSB +: W]),
      .epn_i  (epn_lo[LSB +: W]),
      .force_i(force_grp[g]),
      .ok_o   (grp_ok[g])
    );
  end

  tlbx_hole_decode u_hole (
    .excl_i   (excl_i),
    .unused_i (unused),
    .top_i    (top),
    .epn_lo_i (epn_lo),
    .ea_lo_i  (ea_lo),
    .in_hole_o(in_hole)
  );

  assign match_o = valid_i && size_ok && hi_eq && (&grp_ok) && !in_hole;
endmodule

// File: rtl/tlbx_match_chk.sv
module tlbx_match_chk
  import tlbx_pkg::*;
(
  input logic [0:EA_W-1]  ea_i,
  input logic [0:EPN_W-1] epn_i,
  input logic             valid_i,
  input logic [SZ_W-1:0]  size_i,
  input logic             excl_i,
  input logic             match_o
);
  always_comb begin
    if (!$isunknown({ea_i, epn_i, valid_i, size_i, excl_i, match_o})) begin
      p_invalid_nomatch_r1: assert (valid_i || !match_o)
        else $error("R1 hit on invalid entry");
      p_badsize_nomatch_r2: assert ((size_i < SZ_W'(NSIZE)) || !match_o)
        else $error("R2 hit on unused size code");
      p_high_equal_r3: assert (!match_o || (ea_i[0:HI_W-1] == epn_i[0:HI_W-1]))
        else $error("R3 hit with differing upper bits");
      p_small_full_equal_r4: assert (!match_o || (size_i != 3'd0) || (ea_i[0:EPN_W-1] == epn_i))
        else $error("R4 4KB hit with differing page number");
      p_hole_base_excluded_r7: assert (!match_o || !excl_i || (size_i == 3'd0)
                                       || (ea_i[HI_W:EPN_W-1] != '0) || (size_i != 3'd5))
        else $error("R7 granule 0 of 1GB page hit despite hole");
    end
  end
endmodule

bind tlbx_match tlbx_match_chk u_tlbx_match_chk (
  .ea_i   (ea_i),
  .epn_i  (epn_i),
  .valid_i(valid_i),
  .size_i (size_i),
  .excl_i (excl_i),
  .match_o(match_o)
);

// File: tb/test_tlbx_match.sv
module test_tlbx_match;
  localparam time CLK_P = 10;
  localparam int  MAX_CYC = 190000;

  logic        clk;
  logic [0:63] ea;
  logic [0:51] epn;
  logic        valid, excl;
  logic [2:0]  size;
  logic        match;
  int          n_chk, n_err, cyc;
  bit          done;

  tlbx_match i_tlbx_match (
    .ea_i(ea), .epn_i(epn), .valid_i(valid), .size_i(size), .excl_i(excl), .match_o(match)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic int ubits(int c);
    if (c == 0) return 0;
    if (c >= 5) return 18;
    return 4 * c;
  endfunction

  function automatic int hole_n(logic [51:0] e, int u);
    int n;
    n = 0;
    while (n < u && e[n]) n++;
    if (n > u - 1) n = u - 1;
    return n;
  endfunction

  function automatic bit ref_hit(bit v, int c, bit x, logic [51:0] e, logic [51:0] a);
    int u;
    logic [51:0] m, off;
    if (!v || c > 5) return 1'b0;
    u = ubits(c);
    if ((a >> u) != (e >> u)) return 1'b0;
    if (x && u > 0) begin
      m   = (52'd1 << u) - 52'd1;
      off = a & m;
      if (off < (52'd1 << hole_n(e, u))) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic string req_tag(bit v, int c, bit x, logic [51:0] e, logic [51:0] a, bit odd);
    int u;
    u = ubits(c);
    if (!v) return "R1";
    if (c > 5) return "R2";
    if ((a >> 18) != (e >> 18)) return "R3";
    if (c == 0) return x ? "R6" : "R4";
    if ((a >> u) != (e >> u)) return "R5";
    if (x && odd) return "R8";
    if (x) return "R7";
    return "R5";
  endfunction

  task automatic apply(bit v, int c, bit x, logic [51:0] e, logic [51:0] a,
                       logic [11:0] tail, string tag);
    bit exp;
    @(posedge clk);
    #1;
    valid = v; size = 3'(c); excl = x; epn = e; ea = {a, tail};
    exp = ref_hit(v, c, x, e, a);
    @(negedge clk);
    n_chk++;
    if (match !== exp) begin
      n_err++;
      $display("FAIL %s: size=%0d v=%0b x=%0b epn=%h ea=%h match=%b expected=%b",
               tag, c, v, x, e, a, match, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!done && cyc > MAX_CYC) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=%0d", cyc, MAX_CYC);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [51:0] hi_pat, e, a, m, pat;
    logic [51:0] offs [7];
    int u, n;
    bit odd;
    n_chk = 0; n_err = 0; cyc = 0; done = 1'b0;
    valid = 1'b0; size = 3'd0; excl = 1'b0; epn = '0; ea = '0;
    hi_pat = 52'h9E377_965A5_A5;

    // reset-like state: all-zero invalid entry must not hit (R1)
    apply(1'b0, 0, 1'b0, '0, '0, 12'h000, "R1");

    for (int c = 0; c < 8; c++) begin
      u = (c > 5) ? 18 : ubits(c);
      m = (u == 0) ? '0 : ((52'd1 << u) - 52'd1);
      for (int vv = 0; vv < 2; vv++) begin
        for (int xx = 0; xx < 2; xx++) begin
          for (int p = 0; p <= u + 1; p++) begin
            odd = (p == u + 1) || (p == u && u > 0);
            pat = (p <= u) ? ((52'd1 << p) - 52'd1) : (52'h2_B6D5 & m);
            e   = (hi_pat & ~m) | (pat & m);
            n   = (u > 0) ? hole_n(e, u) : 0;
            offs[0] = '0;
            offs[1] = 52'd1 & m;
            offs[2] = ((52'd1 << n) - 52'd1) & m;
            offs[3] = (52'd1 << n) & m;
            offs[4] = ((52'd1 << n) + 52'd1) & m;
            offs[5] = m;
            offs[6] = (m >> 1) + 52'd3 & m;
            for (int k = 0; k < 7; k++) begin
              a = (e & ~m) | offs[k];
              apply(vv[0], c, xx[0], e, a, 12'(k * 291),
                    req_tag(vv[0], c, xx[0], e, a, odd));
            end
            // single-bit flips at the top offset, exercising R3/R4/R5
            for (int b = 0; b < 52; b++) begin
              a = ((e & ~m) | m) ^ (52'd1 << b);
              apply(vv[0], c, xx[0], e, a, 12'hA5C,
                    req_tag(vv[0], c, xx[0], e, a, odd));
            end
            // R9: low page-offset bits vary, hit must follow ref unchanged
            a = (e & ~m) | m;
            apply(vv[0], c, xx[0], e, a, 12'h000, "R9");
            apply(vv[0], c, xx[0], e, a, 12'hFFF, "R9");
          end
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule